// File: doc/BRIEF.md
# Interrupt Source Bank with Coalescing Status Bits

This block holds the state of a small bank of interrupt sources and feeds them, one at a time, to an interrupt presenter. Each source has a target server number, an 8-bit priority (lower is more urgent, 0xFF means masked), a trigger type (message or level), two status bits that coalesce triggers while a source is in service, a resend flag and a masked-pending flag. Triggers, end-of-interrupt notices and rejections from the presenter all turn into delivery attempts. A single engine carries them out over a handshake with the presenter.

Attempts refused by the presenter are not lost. A refusal is either retried at once or remembered in the source's resend flag. The presenter is told about a remembered refusal by a one-cycle resend-map pulse. A later resend request makes the engine walk the bank one source per cycle and replay every flagged source.

Delivery handshake rules: `dlv_valid` rises with `dlv_src`, `dlv_prio` and `dlv_server`, which stay unchanged until a cycle in which the presenter drives `rsp_valid`. That cycle completes the transfer. `rsp_accept` and `pres_need_resend` are sampled in that cycle only. Only one delivery is outstanding at a time. Back-pressure is applied by withholding `rsp_valid`. Events that arrive in the meantime are held per source and are not dropped.

Top module: `intsrc_ctl`

## Requirements
- R1: The status field of a source is two bits, bit 0 = P (presented), bit 1 = Q (queued). A trigger on a message source sets it to ((PQ << 1) & 3) | 1. The source is offered for delivery only when the result is exactly P=1, Q=0.
- R2: An end-of-interrupt on a message source shifts the status right, so Q moves into P and Q becomes 0. If P is then 1, the source is offered again.
- R3: On a level source, a trigger with `trig_assert`=1 sets P and offers the source only if P was 0. A trigger with `trig_assert`=0 clears P. Q stays 0. An end-of-interrupt leaves the status unchanged and offers the source again if P is 1.
- R4: A source with priority 0xFF is never put on the delivery interface. An attempt on it sets its masked-pending flag instead. A configuration write of a priority other than 0xFF to a source whose masked-pending flag is set clears the flag and makes one delivery attempt at the new priority.
- R5: `dlv_valid`, `dlv_src`, `dlv_prio` and `dlv_server` hold steady until `rsp_valid`. `dlv_prio` and `dlv_server` are the configured values of `dlv_src`.
- R6: A refusal with `pres_need_resend`=1 sets the source's resend flag and pulses `rmap_set` for one cycle, in the cycle after the refusal. The source is not offered again until a resend request.
- R7: A refusal with `pres_need_resend`=0 leaves the resend flag clear and gives no `rmap_set` pulse. The same source is offered again two cycles later.
- R8: `rej_valid` with `rej_src` starts a fresh delivery attempt for that source, whatever its status bits and resend flag.
- R9: `rsd_req` starts a scan over sources 0 to N-1 in ascending order. Each source with its resend flag set has the flag cleared and is attempted. Sources with the flag clear are skipped. `rsd_done` pulses once when the scan ends.
- R10: After reset, `dlv_valid`, `rmap_set` and `rsd_done` are 0. Every source is a message source with status 00, priority 0xFF, and resend and masked-pending flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | SRC_W | Source being configured |
| cfg_prio | input | 8 | Priority to write (0xFF masks) |
| cfg_server | input | SRV_W | Target server to write |
| cfg_level | input | 1 | 1 = level source, 0 = message source |
| trig_valid | input | 1 | Trigger event strobe |
| trig_src | input | SRC_W | Source that is triggered |
| trig_assert | input | 1 | Level value for level sources (ignored for message sources) |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_src | input | SRC_W | Source being ended |
| rej_valid | input | 1 | Presenter rejected a previously delivered source |
| rej_src | input | SRC_W | Rejected source |
| rsd_req | input | 1 | Resend scan request |
| rsd_done | output | 1 | One-cycle pulse at the end of a scan |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_src | output | SRC_W | Source being delivered |
| dlv_prio | output | 8 | Priority of that source |
| dlv_server | output | SRV_W | Target server of that source |
| rsp_valid | input | 1 | Presenter response; completes the handshake |
| rsp_accept | input | 1 | 1 = accepted, 0 = refused |
| pres_need_resend | input | 1 | Presenter's need-resend flag at refusal time |
| rmap_set | output | 1 | Pulse raising this bank's resend-map bit |

## Verification
The hardest situation to reach is a scan that replays several flagged sources. This requires earlier refusals recorded with the presenter's need-resend flag high, at sources spread across the bank. The bench drives fresh attempts on chosen sources through the rejection input while its presenter model refuses them with need-resend high. It then issues a resend request with the presenter accepting, and checks that the replays come out in ascending source order. The status-bit behaviour is swept over every source with a different trigger/end-of-interrupt sequence each, against an arithmetic model of the two bits.

// File: rtl/intsrc_pkg.sv
package intsrc_pkg;
  localparam logic [7:0] PRIO_MASKED = 8'hFF;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_SCAN,
    ENG_ISSUE,
    ENG_WAIT,
    ENG_FIN
  } eng_state_e;
endpackage

// File: rtl/intsrc_bank.sv
module intsrc_bank
  import intsrc_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int SRV_W = 4,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [SRC_W-1:0]            cfg_src,
  input  logic [7:0]                  cfg_prio,
  input  logic [SRV_W-1:0]            cfg_server,
  input  logic                        cfg_level,
  input  logic                        trig_valid,
  input  logic [SRC_W-1:0]            trig_src,
  input  logic                        trig_assert,
  input  logic                        eoi_valid,
  input  logic [SRC_W-1:0]            eoi_src,
  input  logic                        rej_valid,
  input  logic [SRC_W-1:0]            rej_src,
  input  logic [SRC_W-1:0]            eng_cur,
  input  logic                        eng_take,
  input  logic                        eng_set_resend,
  input  logic                        eng_set_mp,
  output logic [N_SRC-1:0]            want_o,
  output logic [N_SRC-1:0]            resend_o,
  output logic [N_SRC-1:0][7:0]       prio_o,
  output logic [N_SRC-1:0][SRV_W-1:0] server_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic [1:0]       pq, pq_e, pq_t;
    logic             is_lvl, rs, mp, want;
    logic [7:0]       pr;
    logic [SRV_W-1:0] sv;
    logic             hit_c, hit_t, hit_e, hit_r, hit_k;
    logic             offer_e, offer_t, kick;

    assign hit_c = cfg_we && (cfg_src == SRC_W'(i));
    assign hit_t = trig_valid && (trig_src == SRC_W'(i));
    assign hit_e = eoi_valid && (eoi_src == SRC_W'(i));
    assign hit_r = rej_valid && (rej_src == SRC_W'(i));
    assign hit_k = eng_cur == SRC_W'(i);
    assign kick  = hit_c && mp && (cfg_prio != PRIO_MASKED);

    always_comb begin
      pq_e    = pq;
      offer_e = 1'b0;
      if (hit_e) begin
        if (is_lvl) begin
          offer_e = pq[0];
        end else begin
          pq_e    = pq >> 1;
          offer_e = pq_e[0];
        end
      end
      pq_t    = pq_e;
      offer_t = 1'b0;
      if (hit_t) begin
        if (is_lvl) begin
          pq_t    = {1'b0, trig_assert};
          offer_t = trig_assert && !pq_e[0];
        end else begin
          pq_t    = ((pq_e << 1) & 2'b11) | 2'b01;
          offer_t = (pq_t == 2'b01);
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pq     <= 2'b00;
        is_lvl <= 1'b0;
        rs     <= 1'b0;
        mp     <= 1'b0;
        want   <= 1'b0;
        pr     <= PRIO_MASKED;
        sv     <= '0;
      end else begin
        pq <= pq_t;
        if (hit_c) begin
          pr     <= cfg_prio;
          sv     <= cfg_server;
          is_lvl <= cfg_level;
        end
        if (kick) mp <= 1'b0;
        else if (eng_set_mp && hit_k) mp <= 1'b1;
        if (eng_set_resend && hit_k) rs <= 1'b1;
        else if (eng_take && hit_k) rs <= 1'b0;
        if (offer_e || offer_t || hit_r || kick) want <= 1'b1;
        else if (eng_take && hit_k) want <= 1'b0;
      end
    end

    assign want_o[i]   = want;
    assign resend_o[i] = rs;
    assign prio_o[i]   = pr;
    assign server_o[i] = sv;
  end
endmodule

// File: rtl/intsrc_pick.sv
module intsrc_pick #(
  parameter int N_SRC = 16,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] req,
  output logic             any,
  output logic [SRC_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = SRC_W'(i);
      end
    end
  end
endmodule

// File: rtl/intsrc_engine.sv
module intsrc_engine
  import intsrc_pkg::*;
#(
  parameter int N_SRC = 16,
  localparam int SRC_W = $clog2(N_SRC),
  localparam logic [SRC_W-1:0] LAST = SRC_W'(N_SRC - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] resend,
  input  logic             any_want,
  input  logic [SRC_W-1:0] pick_src,
  input  logic [7:0]       prio_cur,
  input  logic             rsd_req,
  input  logic             rsp_valid,
  input  logic             rsp_accept,
  input  logic             pres_need_resend,
  output logic [SRC_W-1:0] cur,
  output logic             take,
  output logic             set_resend,
  output logic             set_mp,
  output logic             dlv_valid,
  output logic             rmap_set,
  output logic             rsd_done
);
  eng_state_e       st;
  logic [SRC_W-1:0] idx;
  logic             scan_act, scan_pend;

  assign take       = (st == ENG_ISSUE);
  assign set_mp     = take && (prio_cur == PRIO_MASKED);
  assign dlv_valid  = (st == ENG_WAIT);
  assign set_resend = dlv_valid && rsp_valid && !rsp_accept && pres_need_resend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ENG_IDLE;
      cur       <= '0;
      idx       <= '0;
      scan_act  <= 1'b0;
      scan_pend <= 1'b0;
      rmap_set  <= 1'b0;
      rsd_done  <= 1'b0;
    end else begin
      rmap_set <= 1'b0;
      rsd_done <= 1'b0;
      if (rsd_req) scan_pend <= 1'b1;
      case (st)
        ENG_IDLE: begin
          if (scan_pend) begin
            scan_pend <= rsd_req;
            scan_act  <= 1'b1;
            idx       <= '0;
            st        <= ENG_SCAN;
          end else if (any_want) begin
            cur <= pick_src;
            st  <= ENG_ISSUE;
          end
        end
        ENG_SCAN: begin
          if (resend[idx]) begin
            cur <= idx;
            st  <= ENG_ISSUE;
          end else if (idx == LAST) begin
            rsd_done <= 1'b1;
            scan_act <= 1'b0;
            st       <= ENG_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ENG_ISSUE: st <= (prio_cur == PRIO_MASKED) ? ENG_FIN : ENG_WAIT;
        ENG_WAIT: begin
          if (rsp_valid) begin
            if (rsp_accept) begin
              st <= ENG_FIN;
            end else if (pres_need_resend) begin
              rmap_set <= 1'b1;
              st       <= ENG_FIN;
            end else begin
              st <= ENG_ISSUE;
            end
          end
        end
        ENG_FIN: begin
          if (!scan_act) begin
            st <= ENG_IDLE;
          end else if (idx == LAST) begin
            rsd_done <= 1'b1;
            scan_act <= 1'b0;
            st       <= ENG_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= ENG_SCAN;
          end
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/intsrc_ctl.sv
module intsrc_ctl
  import intsrc_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int SRV_W = 4,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SRC_W-1:0] cfg_src,
  input  logic [7:0]       cfg_prio,
  input  logic [SRV_W-1:0] cfg_server,
  input  logic             cfg_level,
  input  logic             trig_valid,
  input  logic [SRC_W-1:0] trig_src,
  input  logic             trig_assert,
  input  logic             eoi_valid,
  input  logic [SRC_W-1:0] eoi_src,
  input  logic             rej_valid,
  input  logic [SRC_W-1:0] rej_src,
  input  logic             rsd_req,
  output logic             rsd_done,
  output logic             dlv_valid,
  output logic [SRC_W-1:0] dlv_src,
  output logic [7:0]       dlv_prio,
  output logic [SRV_W-1:0] dlv_server,
  input  logic             rsp_valid,
  input  logic             rsp_accept,
  input  logic             pres_need_resend,
  output logic             rmap_set
);
  logic [N_SRC-1:0]            want, resend;
  logic [N_SRC-1:0][7:0]       prio_all;
  logic [N_SRC-1:0][SRV_W-1:0] srv_all;
  logic [SRC_W-1:0]            cur, pick_src;
  logic                        any_want, take, set_resend, set_mp;

  intsrc_bank #(.N_SRC(N_SRC), .SRV_W(SRV_W)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_prio(cfg_prio),
    .cfg_server(cfg_server), .cfg_level(cfg_level),
    .trig_valid(trig_valid), .trig_src(trig_src), .trig_assert(trig_assert),
    .eoi_valid(eoi_valid), .eoi_src(eoi_src),
    .rej_valid(rej_valid), .rej_src(rej_src),
    .eng_cur(cur), .eng_take(take), .eng_set_resend(set_resend), .eng_set_mp(set_mp),
    .want_o(want), .resend_o(resend), .prio_o(prio_all), .server_o(srv_all)
  );

  intsrc_pick #(.N_SRC(N_SRC)) pick_i (
    .req(want), .any(any_want), .idx(pick_src)
  );

  intsrc_engine #(.N_SRC(N_SRC)) eng_i (
    .clk(clk), .rst_n(rst_n),
    .resend(resend), .any_want(any_want), .pick_src(pick_src),
    .prio_cur(prio_all[cur]), .rsd_req(rsd_req),
    .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
    .pres_need_resend(pres_need_resend),
    .cur(cur), .take(take), .set_resend(set_resend), .set_mp(set_mp),
    .dlv_valid(dlv_valid), .rmap_set(rmap_set), .rsd_done(rsd_done)
  );

  assign dlv_src    = cur;
  assign dlv_prio   = prio_all[cur];
  assign dlv_server = srv_all[cur];
endmodule

// File: rtl/intsrc_ctl_chk.sv
module intsrc_ctl_chk #(
  parameter int N_SRC = 16,
  parameter int SRV_W = 4,
  localparam int SRC_W = $clog2(N_SRC)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dlv_valid,
  input logic [SRC_W-1:0] dlv_src,
  input logic [7:0]       dlv_prio,
  input logic [SRV_W-1:0] dlv_server,
  input logic             rsp_valid,
  input logic             rsp_accept,
  input logic             pres_need_resend,
  input logic             rmap_set,
  input logic             rsd_done
);
  AST_DLV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !rsp_valid |=> dlv_valid && $stable(dlv_src) && $stable(dlv_prio) && $stable(dlv_server)); // R5

  AST_NO_MASKED_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> dlv_prio != 8'hFF); // R4

  AST_RMAP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    rmap_set |-> $past(dlv_valid && rsp_valid && !rsp_accept && pres_need_resend)); // R6

  AST_RMAP_ON_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && rsp_valid && !rsp_accept && pres_need_resend |=> rmap_set); // R6

  AST_RETRY_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && rsp_valid && !rsp_accept && !pres_need_resend |=> !rmap_set ##1 (dlv_src == $past(dlv_src, 2))); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsd_done |=> !rsd_done); // R9
endmodule

bind intsrc_ctl intsrc_ctl_chk #(.N_SRC(N_SRC), .SRV_W(SRV_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .dlv_valid(dlv_valid), .dlv_src(dlv_src),
  .dlv_prio(dlv_prio), .dlv_server(dlv_server), .rsp_valid(rsp_valid),
  .rsp_accept(rsp_accept), .pres_need_resend(pres_need_resend),
  .rmap_set(rmap_set), .rsd_done(rsd_done)
);

// File: tb/intsrc_ctl_tb_top.sv
module intsrc_ctl_tb_top;
  localparam int N = 16;
  localparam int SW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_level = 0, trig_valid = 0, trig_assert = 0;
  logic eoi_valid = 0, rej_valid = 0, rsd_req = 0;
  logic [3:0] cfg_src = 0, trig_src = 0, eoi_src = 0, rej_src = 0;
  logic [7:0] cfg_prio = 0;
  logic [SW-1:0] cfg_server = 0;
  logic rsp_valid = 0, rsp_accept = 0, pres_need_resend = 0;
  logic rsd_done, dlv_valid, rmap_set;
  logic [3:0] dlv_src;
  logic [7:0] dlv_prio;
  logic [SW-1:0] dlv_server;

  int checks = 0, fails = 0, cyc = 0;
  int dcnt [N];
  int expc [N];
  logic [7:0] lprio [N];
  logic [SW-1:0] lsrv;
  int ord [64];
  int ordn = 0, rmapn = 0, donen = 0, refuse_n = 0;
  bit nr_val = 0;
  logic [1:0] pqm [N];
  bit finished = 0;

  always #10 clk = ~clk;

  intsrc_ctl #(.N_SRC(N), .SRV_W(SW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src), .cfg_prio(cfg_prio),
    .cfg_server(cfg_server), .cfg_level(cfg_level), .trig_valid(trig_valid),
    .trig_src(trig_src), .trig_assert(trig_assert), .eoi_valid(eoi_valid),
    .eoi_src(eoi_src), .rej_valid(rej_valid), .rej_src(rej_src), .rsd_req(rsd_req),
    .rsd_done(rsd_done), .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_prio(dlv_prio),
    .dlv_server(dlv_server), .rsp_valid(rsp_valid), .rsp_accept(rsp_accept),
    .pres_need_resend(pres_need_resend), .rmap_set(rmap_set)
  );

  // presenter model and monitor
  always @(negedge clk) begin
    if (rmap_set) rmapn++;
    if (rsd_done) donen++;
    if (dlv_valid) begin
      dcnt[dlv_src]++;
      lprio[dlv_src] = dlv_prio;
      lsrv = dlv_server;
      ord[ordn % 64] = int'(dlv_src);
      ordn++;
      rsp_valid = 1'b1;
      pres_need_resend = nr_val;
      if (refuse_n > 0) begin rsp_accept = 1'b0; refuse_n--; end
      else rsp_accept = 1'b1;
    end else begin
      rsp_valid = 1'b0;
      rsp_accept = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_cfg(input int s, input int p, input int sv, input bit lvl);
    @(negedge clk);
    cfg_we = 1; cfg_src = 4'(s); cfg_prio = 8'(p); cfg_server = SW'(sv); cfg_level = lvl;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic do_trig(input int s, input bit a);
    @(negedge clk);
    trig_valid = 1; trig_src = 4'(s); trig_assert = a;
    @(negedge clk);
    trig_valid = 0;
  endtask

  task automatic do_eoi(input int s);
    @(negedge clk);
    eoi_valid = 1; eoi_src = 4'(s);
    @(negedge clk);
    eoi_valid = 0;
  endtask

  task automatic do_rej(input int s);
    @(negedge clk);
    rej_valid = 1; rej_src = 4'(s);
    @(negedge clk);
    rej_valid = 0;
  endtask

  task automatic do_rsd();
    @(negedge clk);
    rsd_req = 1;
    @(negedge clk);
    rsd_req = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      summary();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin dcnt[i] = 0; expc[i] = 0; pqm[i] = 2'b00; end
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(dlv_valid == 0, "R10 dlv_valid", int'(dlv_valid), 0);
    chk(rmap_set == 0, "R10 rmap_set", int'(rmap_set), 0);
    chk(rsd_done == 0, "R10 rsd_done", int'(rsd_done), 0);
    rst_n = 1;
    settle(2);
    // R10/R4: source 0 still masked after reset; trigger is withheld
    do_trig(0, 1'b1);
    pqm[0] = 2'b01;
    settle(10);
    chk(dcnt[0] == 0, "R10 masked after reset", dcnt[0], 0);
    // configure every source as message type
    for (int s = 0; s < N; s++) do_cfg(s, s * 7 + 3, s ^ 5, 1'b0);
    settle(10);
    chk(dcnt[0] == 1, "R4 unmask kick", dcnt[0], 1);
    chk(lprio[0] == 8'd3, "R4 unmask prio", int'(lprio[0]), 3);
    expc[0] = 1;
    // R1/R2: PQ sweep over every source
    for (int s = 0; s < N; s++) begin
      logic [7:0] pat;
      pat = 8'(s * 29 + 75);
      for (int k = 0; k < 8; k++) begin
        bit hit;
        if (pat[k]) begin
          pqm[s] = ((pqm[s] << 1) & 2'b11) | 2'b01;
          hit = (pqm[s] == 2'b01);
          do_trig(s, 1'b0);
        end else begin
          pqm[s] = pqm[s] >> 1;
          hit = pqm[s][0];
          do_eoi(s);
        end
        settle(8);
        if (hit) expc[s]++;
        chk(dcnt[s] == expc[s], pat[k] ? "R1 trigger count" : "R2 eoi count", dcnt[s], expc[s]);
        if (hit) begin
          chk(lprio[s] == 8'(s * 7 + 3), "R5 prio", int'(lprio[s]), s * 7 + 3);
          chk(lsrv == SW'(s ^ 5), "R5 server", int'(lsrv), s ^ 5);
        end
      end
    end
    // R3: level source
    do_cfg(6, 20, 6, 1'b1);
    do_trig(6, 1'b0); settle(8);
    chk(dcnt[6] == expc[6], "R3 deassert", dcnt[6], expc[6]);
    do_trig(6, 1'b1); settle(8); expc[6]++;
    chk(dcnt[6] == expc[6], "R3 assert", dcnt[6], expc[6]);
    do_trig(6, 1'b1); settle(8);
    chk(dcnt[6] == expc[6], "R3 assert again", dcnt[6], expc[6]);
    do_eoi(6); settle(8); expc[6]++;
    chk(dcnt[6] == expc[6], "R3 eoi while high", dcnt[6], expc[6]);
    do_trig(6, 1'b0); do_eoi(6); settle(8);
    chk(dcnt[6] == expc[6], "R3 eoi after low", dcnt[6], expc[6]);
    // R4: masked source via rejection, then unmask
    do_cfg(7, 255, 7, 1'b0);
    do_rej(7); settle(8);
    chk(dcnt[7] == expc[7], "R4 masked held", dcnt[7], expc[7]);
    do_cfg(7, 51, 7, 1'b0); settle(8); expc[7]++;
    chk(dcnt[7] == expc[7], "R4 unmask delivers", dcnt[7], expc[7]);
    chk(lprio[7] == 8'd51, "R4 new prio", int'(lprio[7]), 51);
    // R8: rejection gives fresh delivery
    do_rej(11); settle(8); expc[11]++;
    chk(dcnt[11] == expc[11], "R8 reject redeliver", dcnt[11], expc[11]);
    // R6: refusal remembered
    refuse_n = 1; nr_val = 1;
    do_rej(3); settle(10); expc[3]++;
    chk(dcnt[3] == expc[3], "R6 single attempt", dcnt[3], expc[3]);
    chk(rmapn == 1, "R6 rmap pulse", rmapn, 1);
    settle(10);
    chk(dcnt[3] == expc[3], "R6 no replay", dcnt[3], expc[3]);
    do_rsd(); settle(30); expc[3]++;
    chk(dcnt[3] == expc[3], "R9 replay", dcnt[3], expc[3]);
    chk(donen == 1, "R9 done", donen, 1);
    do_rsd(); settle(30);
    chk(dcnt[3] == expc[3], "R9 flag cleared skip", dcnt[3], expc[3]);
    chk(donen == 2, "R9 done again", donen, 2);
    // R7: refusal without need-resend retries at once
    refuse_n = 1; nr_val = 0;
    do_rej(4); settle(10); expc[4] += 2;
    chk(dcnt[4] == expc[4], "R7 retry", dcnt[4], expc[4]);
    chk(rmapn == 1, "R7 no rmap", rmapn, 1);
    // R9: scan order over several flagged sources
    nr_val = 1;
    refuse_n = 1; do_rej(9); settle(8);
    refuse_n = 1; do_rej(2); settle(8);
    refuse_n = 1; do_rej(13); settle(8);
    chk(rmapn == 4, "R6 three pulses", rmapn, 4);
    nr_val = 0;
    do_rsd(); settle(40);
    chk(ord[(ordn - 3) % 64] == 2, "R9 order first", ord[(ordn - 3) % 64], 2);
    chk(ord[(ordn - 2) % 64] == 9, "R9 order second", ord[(ordn - 2) % 64], 9);
    chk(ord[(ordn - 1) % 64] == 13, "R9 order third", ord[(ordn - 1) % 64], 13);
    chk(donen == 3, "R9 done third", donen, 3);
    finished = 1;
    summary();
  end
endmodule